// File: doc/BRIEF.md
# Three-Wire SPI Master with Control and Status Byte

This block is a serial peripheral master that drives a clock and a data-out line and samples a data-in line, moving one byte per transfer. Software reaches it through a simple write port that selects either the data register or a byte-wide control/status register. A byte written to the data register lands in a single-entry transmit buffer. The buffer hands the byte to the shift register as soon as the shifter is free, so software can queue the next byte while the current one is still on the wire.

Three sticky flags report the end of a transfer, a rejected write and a master collision on the external select input. They stay set until software writes a zero to them. Any set flag raises the interrupt output while the interrupt-enable input is high. The serial clock is the system clock divided by a fixed parameter. It idles low, data out changes on the falling edge, data in is sampled on the rising edge, and the most significant bit goes first. Only three-wire master operation exists; the select-mode field is stored so that the collision check can use it.

Top module: `spi3w_master`

## Requirements
- R1: After reset the control byte reads 0x06, sck and mosi are low and irq is low. Control byte fields: bit 7 transfer-done flag, bit 6 write-collision flag, bit 5 mode-fault flag, bit 4 reserved, bits 3:2 select mode, bit 1 buffer-empty, bit 0 enable.
- R2: Each transfer gives exactly 8 rising sck edges. sck idles low and each sck level lasts HALF_DIV clock cycles. mosi holds the transmit byte MSB first and is valid at every rising edge.
- R3: The transfer-done flag (bit 7) sets when the eighth bit completes and stays set until software clears it.
- R4: The buffer-empty bit (bit 1) reads 0 in the cycle after an accepted data write. It returns to 1 once the byte moves into the shifter: one cycle later if the shifter is idle, otherwise when the current transfer ends.
- R5: A data write while enabled and while the buffer still holds an unsent byte sets the write-collision flag (bit 6). That written byte is discarded and never transmitted.
- R6: With enable set and select mode equal to 01, a low nss_in sets the mode-fault flag (bit 5) on the next clock. With select mode 00, nss_in has no effect.
- R7: A control write clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1. A hardware set in the same cycle wins over a clear.
- R8: irq is high exactly when irq_en is high and at least one of the three flags is set.
- R9: Clearing enable aborts any transfer: sck is low from the next cycle, the buffer empties (bit 1 reads 1) and no done flag follows. Data writes while disabled are ignored.
- R10: Bit 4 always reads 0 and bit 1 cannot be written. Control writes store bits 3:2 and bit 0.
- R11: When the done flag rises, rx_q holds the byte sampled from miso, MSB first, and stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the data register, 1 the control byte |
| wr_data | input | 8 | Write data |
| irq_en | input | 1 | Interrupt enable |
| nss_in | input | 1 | External select line monitored for master collision |
| miso | input | 1 | Serial data in |
| ctrl_q | output | 8 | Control/status byte readback |
| rx_q | output | 8 | Last received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a write strobe lasts one cycle and carries only one register access. They also assume that nss_in and miso are stable around the clock edge, which a real system guarantees with a synchronizer outside this block. The bench drives every input at the falling clock edge and changes miso only on falling sck edges, well before the design samples it. Writes are single-cycle pulses issued from tasks. The bench drops the sck half-period check only during the deliberate disable abort, where a short final sck level is the expected result.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h06;

    // Field positions that software decodes
    localparam int F_DONE  = 7;
    localparam int F_WCOL  = 6;
    localparam int F_MODF  = 5;
    localparam int F_MODE0 = 2;
    localparam int F_EN    = 0;

    localparam logic [1:0] MODE_COLLIDE = 2'b01;

    typedef struct packed {
        logic       done;
        logic       wcol;
        logic       modf;
        logic       rsvd;
        logic [1:0] mode;
        logic       empty;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic       keep_done;
        logic       keep_wcol;
        logic       keep_modf;
        logic [1:0] mode;
        logic       en;
    } ctrl_wr_t;

    typedef enum logic {SH_IDLE = 1'b0, SH_RUN = 1'b1} sh_state_e;

    function automatic ctrl_wr_t decode_ctrl(input logic [BYTE_W-1:0] d);
        ctrl_wr_t w;
        w.keep_done = d[F_DONE];
        w.keep_wcol = d[F_WCOL];
        w.keep_modf = d[F_MODF];
        w.mode      = d[F_MODE0 +: 2];
        w.en        = d[F_EN];
        return w;
    endfunction

endpackage

// File: rtl/spi3w_txbuf.sv
module spi3w_txbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            full <= 1'b0;
        end else if (push) begin
            full <= 1'b1;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (push) begin
            data <= push_data;
        end
    end
endmodule

// File: rtl/spi3w_shifter.sv
module spi3w_shifter
    import spi3w_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic [DW-1:0] tx_data,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int CNT_W = $clog2(DW);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DW - 1);

    sh_state_e        state;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shreg;
    logic             sampled;
    logic             phase_end;

    assign phase_end = (div_cnt == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= SH_IDLE;
            sck     <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
            shreg   <= '0;
            sampled <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg   <= tx_data;
                        state   <= SH_RUN;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                    end
                end
                SH_RUN: begin
                    if (!phase_end) begin
                        div_cnt <= div_cnt + 1'b1;
                    end else begin
                        div_cnt <= '0;
                        if (!sck) begin
                            sck     <= 1'b1;
                            sampled <= miso;
                        end else begin
                            sck   <= 1'b0;
                            shreg <= {shreg[DW-2:0], sampled};
                            if (bit_cnt == BIT_LAST) begin
                                state <= SH_IDLE;
                                done  <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Received byte is kept across disable so software can still read it
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
        end else if (state == SH_RUN && phase_end && sck && bit_cnt == BIT_LAST) begin
            rx_data <= {shreg[DW-2:0], sampled};
        end
    end

    assign busy = (state == SH_RUN);
    assign mosi = busy & shreg[DW-1];
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
    import spi3w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctrl_wr,
    input  ctrl_wr_t ctrl_in,
    input  logic     data_wr,
    input  logic     buf_full,
    input  logic     xfer_done,
    input  logic     nss_in,
    output logic     en,
    output logic     push,
    output ctrl_t    ctrl
);
    logic       done_f, wcol_f, modf_f;
    logic [1:0] mode;
    logic       collide_wr;
    logic       nss_fault;

    assign push       = data_wr & en & ~buf_full;
    assign collide_wr = data_wr & en & buf_full;
    assign nss_fault  = en & (mode == MODE_COLLIDE) & ~nss_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_f <= CTRL_RESET[F_DONE];
            wcol_f <= CTRL_RESET[F_WCOL];
            modf_f <= CTRL_RESET[F_MODF];
            mode   <= CTRL_RESET[F_MODE0 +: 2];
            en     <= CTRL_RESET[F_EN];
        end else begin
            if (ctrl_wr) begin
                mode <= ctrl_in.mode;
                en   <= ctrl_in.en;
            end
            done_f <= (done_f & ~(ctrl_wr & ~ctrl_in.keep_done)) | xfer_done;
            wcol_f <= (wcol_f & ~(ctrl_wr & ~ctrl_in.keep_wcol)) | collide_wr;
            modf_f <= (modf_f & ~(ctrl_wr & ~ctrl_in.keep_modf)) | nss_fault;
        end
    end

    always_comb begin
        ctrl.done  = done_f;
        ctrl.wcol  = wcol_f;
        ctrl.modf  = modf_f;
        ctrl.rsvd  = 1'b0;
        ctrl.mode  = mode;
        ctrl.empty = ~buf_full;
        ctrl.en    = en;
    end
endmodule

// File: rtl/spi3w_master.sv
module spi3w_master
    import spi3w_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              nss_in,
    input  logic              miso,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] rx_q,
    output logic              sck,
    output logic              mosi,
    output logic              irq
);
    ctrl_t             ctrl;
    logic              en, push, buf_full, busy, xfer_done, start;
    logic [BYTE_W-1:0] buf_data;

    assign start = buf_full & ~busy;

    spi3w_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (wr_en & wr_sel),
        .ctrl_in   (decode_ctrl(wr_data)),
        .data_wr   (wr_en & ~wr_sel),
        .buf_full  (buf_full),
        .xfer_done (xfer_done),
        .nss_in    (nss_in),
        .en        (en),
        .push      (push),
        .ctrl      (ctrl)
    );

    spi3w_txbuf #(.DW(BYTE_W)) u_txbuf (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .push      (push),
        .push_data (wr_data),
        .pop       (start),
        .full      (buf_full),
        .data      (buf_data)
    );

    spi3w_shifter #(.DW(BYTE_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .start   (start),
        .tx_data (buf_data),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .busy    (busy),
        .done    (xfer_done),
        .rx_data (rx_q)
    );

    assign ctrl_q = ctrl;
    assign irq    = irq_en & (ctrl.done | ctrl.wcol | ctrl.modf);
endmodule

// File: rtl/spi3w_master_chk.sv
module spi3w_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       irq_en,
    input logic       nss_in,
    input logic [7:0] ctrl_q,
    input logic [7:0] rx_q,
    input logic       sck,
    input logic       irq
);
    // R9: a disabled block holds sck low from the following cycle
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[0] |=> !sck);

    // R3: done flag persists unless a control write clears it
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] && !(wr_en && wr_sel && !wr_data[7])) |=> ctrl_q[7]);

    // R4: accepted data write empties nothing, it fills the buffer
    p_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && ctrl_q[0] && ctrl_q[1]) |=> !ctrl_q[1]);

    // R5: data write into an occupied buffer raises the collision flag
    p_wcol_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && ctrl_q[0] && !ctrl_q[1]) |=> ctrl_q[6]);

    // R6: collision on the select line in mode 01
    p_modf_r6: assert property (@(posedge clk) disable iff (rst)
        (!nss_in && ctrl_q[0] && ctrl_q[3:2] == 2'b01) |=> ctrl_q[5]);

    // R8: interrupt needs the enable and follows any flag
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en && (ctrl_q[7] || ctrl_q[6] || ctrl_q[5])) |-> irq);

    // R11: received byte is already final when the done flag rises
    p_rx_stable_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[7]) |=> $stable(rx_q));
endmodule

bind spi3w_master spi3w_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq_en  (irq_en),
    .nss_in  (nss_in),
    .ctrl_q  (ctrl_q),
    .rx_q    (rx_q),
    .sck     (sck),
    .irq     (irq)
);

// File: tb/spi3w_master_test.sv
module spi3w_master_test;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, irq_en = 1'b0, nss_in = 1'b1;
    logic [7:0] wr_data = '0;
    logic       miso;
    logic [7:0] ctrl_q, rx_q;
    logic       sck, mosi, irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    spi3w_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_en(irq_en), .nss_in(nss_in), .miso(miso), .ctrl_q(ctrl_q),
        .rx_q(rx_q), .sck(sck), .mosi(mosi), .irq(irq)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 90);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Scoreboard and slave model
    logic [7:0] exp_q[$];
    logic [7:0] cap = '0;
    int         cap_cnt = 0;
    int         xfer_idx = 0;
    logic [2:0] bit_idx = '0;
    logic [7:0] cur_pat;
    logic       resync = 1'b0;
    bit         aborting = 0;
    time        t_rise = 0;

    always_comb begin
        cur_pat = pat(xfer_idx);
        miso    = cur_pat[3'd7 - bit_idx];
    end

    // monitor: mosi bytes at rising sck (R2)
    always @(posedge sck or posedge resync) begin
        if (resync) begin
            cap_cnt = 0;
        end else begin
            t_rise = $time;
            cap = {cap[6:0], mosi};
            cap_cnt++;
            if (cap_cnt == 8) begin
                cap_cnt = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R2/R5 unexpected byte", cap, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(cap == e, "R2 mosi byte", cap, e);
                end
            end
        end
    end

    // slave: advance miso on falling sck, check half period (R2)
    always @(negedge sck or posedge resync) begin
        if (resync) begin
            bit_idx = '0;
            xfer_idx++;
        end else begin
            if (!aborting)
                check(($time - t_rise) == HALF * 10, "R2 sck high time",
                      int'($time - t_rise), HALF * 10);
            if (bit_idx == 3'd7) begin
                bit_idx = '0;
                xfer_idx++;
            end else begin
                bit_idx++;
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_q.push_back(d);
        wr(1'b0, d);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !ctrl_q[7]; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ctrl_q == 8'h06, "R1 reset ctrl", ctrl_q, 8'h06);
        check(!sck && !mosi && !irq, "R1 reset outputs", {sck, mosi, irq}, 0);

        // R10: reserved and empty bits not writable
        wr(1'b1, 8'h11);
        check(ctrl_q == 8'h03, "R10 ctrl readback", ctrl_q, 8'h03);

        // single transfer
        irq_en = 1'b1;
        send(8'hA5);
        check(ctrl_q[1] == 1'b0, "R4 empty after write", ctrl_q[1], 0);
        @(negedge clk);
        check(ctrl_q[1] == 1'b1, "R4 empty after handoff", ctrl_q[1], 1);
        wait_done();
        check(ctrl_q[7], "R3 done set", ctrl_q, 8'h83);
        check(rx_q == pat(0), "R11 rx byte", rx_q, pat(0));
        check(irq, "R8 irq on done", irq, 1);
        repeat (5) @(negedge clk);
        check(ctrl_q[7], "R3 done sticky", ctrl_q[7], 1);
        wr(1'b1, 8'hE1);
        check(ctrl_q == 8'h83, "R7 write one keeps", ctrl_q, 8'h83);
        wr(1'b1, 8'h01);
        check(ctrl_q == 8'h03, "R7 write zero clears", ctrl_q, 8'h03);
        check(!irq, "R8 irq low no flags", irq, 0);

        // queued byte plus collision
        send(8'h3C);
        repeat (3) @(negedge clk);
        send(8'hC3);
        check(ctrl_q[1] == 1'b0 && ctrl_q[6] == 1'b0, "R4 queued while busy",
              ctrl_q, 8'h01);
        wr(1'b0, 8'h77);
        check(ctrl_q[6], "R5 collision flag", ctrl_q[6], 1);
        check(irq, "R8 irq on collision", irq, 1);
        repeat (10) @(negedge clk);
        check(ctrl_q[1] == 1'b0, "R4 held until transfer ends", ctrl_q[1], 0);
        wait_done();
        check(rx_q == pat(1), "R11 rx first queued", rx_q, pat(1));
        check(ctrl_q[1] == 1'b1, "R4 handoff at transfer end", ctrl_q[1], 1);
        wr(1'b1, 8'h01);
        check(ctrl_q == 8'h03, "R7 clear all", ctrl_q, 8'h03);
        wait_done();
        check(rx_q == pat(2), "R11 rx second queued", rx_q, pat(2));
        wr(1'b1, 8'h01);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 discarded byte absent", exp_q.size(), 0);

        // mode fault
        nss_in = 1'b0;
        repeat (3) @(negedge clk);
        check(ctrl_q[5] == 1'b0, "R6 mode 00 ignores nss", ctrl_q[5], 0);
        wr(1'b1, 8'h05);
        @(negedge clk);
        check(ctrl_q[5], "R6 mode fault", ctrl_q[5], 1);
        nss_in = 1'b1;
        wr(1'b1, 8'h01);
        check(ctrl_q == 8'h03, "R7 clear fault", ctrl_q, 8'h03);

        // disable abort
        irq_en = 1'b0;
        wr(1'b0, 8'h99);
        repeat (10) @(negedge clk);
        aborting = 1;
        wr(1'b1, 8'h00);
        @(negedge clk);
        check(!sck, "R9 sck low after disable", sck, 0);
        check(ctrl_q == 8'h02, "R9 buffer emptied", ctrl_q, 8'h02);
        resync = 1'b1; #1; resync = 1'b0;
        aborting = 0;
        wr(1'b0, 8'h55);
        check(ctrl_q == 8'h02, "R9 write ignored when disabled", ctrl_q, 8'h02);
        repeat (40) @(negedge clk);
        check(ctrl_q[7] == 1'b0, "R9 no done after abort", ctrl_q[7], 0);

        // re-enable, one more byte, interrupt gating
        wr(1'b1, 8'h01);
        send(8'h5A);
        wait_done();
        check(rx_q == pat(4), "R11 rx after abort", rx_q, pat(4));
        check(!irq, "R8 irq gated off", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq, "R8 irq gated on", irq, 1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule